// File: doc/BRIEF.md
# Console Serial Port Register Block

This block is the register front end of a console serial port. A processor reaches it over a simple word-wide register bus. The bus has an address, a write strobe, a read strobe, write data and combinational read data. Characters arrive whole, one byte at a time, from a receive source that holds a byte and a valid flag until the block pops it. Characters leave as a one-cycle strobe carrying a byte. The block has no baud-rate generator, no shift register, no parity and no FIFO.

Receive and transmit each have a status register with an interrupt-enable bit and a flag bit. The receive flag shows whether a character is waiting. It follows the receive valid input directly and is never latched. The transmit flag reports a ready transmitter at all times after reset.

An interrupt cause exists when receive interrupts are enabled and a character is waiting, or when transmit interrupts are enabled. While a cause exists, the block drives a level interrupt request and an 8-bit vector that names the cause. It also sets a sticky pending bit in a 32-bit system status word. Software clears the pending bit by writing either status register.

Top module: `cons_port`

## Requirements
- R1: Decoding uses a 9-bit word address. The receive status register is at 0x80 and receive data is at 0x84. Transmit status is at 0x88 and transmit data is at 0x8C. An identification register is at 0x100, and 0x108 is a write-only scratch location.
- R2: In both status registers, bit 6 holds the interrupt-enable bit last written there. In the receive status register, bit 7 equals the present `rx_valid` input. All other read bits are zero.
- R3: The transmit status register reads bit 7 as 1 from the first cycle after reset onward.
- R4: A write to 0x8C pulses `tx_valid` for exactly one cycle, starting at the clock edge that accepts the write. `tx_byte` carries bits 7:0 of the write data.
- R5: Reading 0x84 while `rx_valid` is high returns `rx_byte` and pulses `rx_ready` in that same cycle. Reading it while `rx_valid` is low returns zero and leaves `rx_ready` low.
- R6: A receive cause (receive enable set and `rx_valid` high) raises `irq` one cycle after the cause appears, with `irq_vector` equal to 0xF8.
- R7: A transmit cause (transmit enable set) raises `irq` one cycle after the cause appears, with `irq_vector` equal to 0xFC.
- R8: When both causes are active, `irq_vector` is 0xF8. It becomes 0xFC one cycle after the receive cause goes away while the transmit cause remains.
- R9: Bit 28 of `sys_status` is set whenever a cause exists. It stays set after the cause goes away, while `irq` falls. A write to either status register clears bit 28 and drops `irq` at that edge, and a cause that is still present raises both again one cycle later. All other bits of `sys_status` read zero.
- R10: Reading 0x100 returns 128. Reading 0x108 returns zero. Writes to 0x100 or 0x108 change no register and strobe no output.
- R11: Reads from unmapped addresses return zero and pop nothing. Writes to unmapped addresses, including those that differ from a mapped address only in bit 8, have no effect.
- R12: While reset is low, `irq`, `irq_vector`, `sys_status`, `tx_valid` and both enable bits are zero, and the transmit ready bit reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 9 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| rx_byte | input | 8 | Incoming character |
| rx_valid | input | 1 | Incoming character present |
| rx_ready | output | 1 | Pop pulse for the incoming character |
| tx_byte | output | 8 | Outgoing character |
| tx_valid | output | 1 | One-cycle strobe for an outgoing character |
| irq | output | 1 | Level interrupt request |
| irq_vector | output | 8 | Vector of the latest cause (0xF8 receive, 0xFC transmit) |
| sys_status | output | 32 | System status word; bit 28 is the sticky pending flag |

## Verification
The interrupt path is exercised with four patterns: receive cause alone, transmit cause alone, both causes at once, and a receive cause that disappears after a pop. Together they separate vector selection, priority and the sticky-versus-level split between `sys_status` bit 28 and `irq`. Status rewrites with the enable kept set show the one-cycle drop and the recovery. Reads of receive data with and without a character show that the pop is gated and that empty reads return zero. Writes to 0x100, 0x108 and to mapped offsets with bit 8 set reveal incomplete address decoding, because any side effect would show up in the status readback or on `tx_valid`.

// File: rtl/cons_pkg.sv
// Shared constants for the console port: register offsets, status bit
// positions and interrupt vector values.
package cons_pkg;
    localparam int OFS_RX_STAT = 32'h080;
    localparam int OFS_RX_DATA = 32'h084;
    localparam int OFS_TX_STAT = 32'h088;
    localparam int OFS_TX_DATA = 32'h08C;
    localparam int OFS_ID      = 32'h100;
    localparam int ID_VALUE    = 128;
    localparam int IE_BIT      = 6;
    localparam int FLAG_BIT    = 7;
    localparam logic [7:0] VEC_RX = 8'hF8;
    localparam logic [7:0] VEC_TX = 8'hFC;
endpackage

// File: rtl/cons_rx_path.sv
// Receive side: holds the receive interrupt enable, builds the receive
// status byte and the receive data read value, and generates the pop pulse.
// Assumes the source holds rx_byte stable while rx_valid is high.
module cons_rx_path
    import cons_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic              wr_ie,
    input  logic              data_rd,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              ie,
    output logic [CHAR_W-1:0] stat_byte,
    output logic [CHAR_W-1:0] data_byte
);
    // Enable bit: loaded on a status write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       ie <= 1'b0;
        else if (stat_wr) ie <= wr_ie;
    end

    // Status byte: live availability flag plus the stored enable.
    always_comb begin
        stat_byte           = '0;
        stat_byte[FLAG_BIT] = rx_valid;
        stat_byte[IE_BIT]   = ie;
    end

    // Data read value and pop pulse, both gated by availability.
    always_comb begin
        data_byte = rx_valid ? rx_byte : '0;
        rx_ready  = data_rd && rx_valid;
    end

    AST_RX_IE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ie == $past(ie)); // R2
endmodule

// File: rtl/cons_tx_path.sv
// Transmit side: holds the transmit interrupt enable and the always-ready
// flag, builds the transmit status byte, and registers the outgoing strobe.
module cons_tx_path
    import cons_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic              wr_ie,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wr_byte,
    output logic              ie,
    output logic [CHAR_W-1:0] stat_byte,
    output logic [CHAR_W-1:0] tx_byte,
    output logic              tx_valid
);
    logic rdy_q;

    // Enable bit and ready flag; ready comes up on the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie    <= 1'b0;
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= 1'b1;
            if (stat_wr) ie <= wr_ie;
        end
    end

    // Outgoing character strobe, one cycle per data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= data_wr;
            if (data_wr) tx_byte <= wr_byte;
        end
    end

    // Status byte: ready flag plus the stored enable.
    always_comb begin
        stat_byte           = '0;
        stat_byte[FLAG_BIT] = rdy_q;
        stat_byte[IE_BIT]   = ie;
    end

    AST_TX_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |=> rdy_q); // R3
endmodule

// File: rtl/cons_irq_ctl.sv
// Interrupt control: turns the two causes into a level request, a vector
// with receive priority, and a sticky pending flag cleared by status writes.
module cons_irq_ctl
    import cons_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_cause,
    input  logic       tx_cause,
    input  logic       stat_wr,
    output logic       irq,
    output logic       pend,
    output logic [7:0] vec
);
    logic any_cause;
    assign any_cause = rx_cause || tx_cause;

    // Request, sticky flag and vector, all registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            pend <= 1'b0;
            vec  <= '0;
        end else begin
            irq <= any_cause && !stat_wr;
            if (stat_wr)        pend <= 1'b0;
            else if (any_cause) pend <= 1'b1;
            if (rx_cause)       vec  <= VEC_RX;
            else if (tx_cause)  vec  <= VEC_TX;
        end
    end

    AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend); // R9
    AST_IRQ_VEC_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec == VEC_RX || vec == VEC_TX)); // R6
    AST_CLEAR_ON_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> !pend && !irq); // R9
endmodule

// File: rtl/cons_port.sv
// Console port top: decodes the register bus, multiplexes read data and
// connects the receive path, transmit path and interrupt control.
// Assumes single-cycle bus strobes; read data is combinational on bus_addr.
module cons_port
    import cons_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 32,
    parameter int CHAR_W   = 8,
    parameter int PEND_BIT = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [CHAR_W-1:0] tx_byte,
    output logic              tx_valid,
    output logic              irq,
    output logic [7:0]        irq_vector,
    output logic [DATA_W-1:0] sys_status
);
    logic sel_rxs, sel_rxd, sel_txs, sel_txd, sel_id;
    logic rx_ie, tx_ie, pend;
    logic [CHAR_W-1:0] rx_stat, rx_data, tx_stat;
    logic unused_wbits;

    assign unused_wbits = ^bus_wdata[DATA_W-1:CHAR_W];

    // Full-width address decode.
    always_comb begin
        sel_rxs = bus_addr == ADDR_W'(OFS_RX_STAT);
        sel_rxd = bus_addr == ADDR_W'(OFS_RX_DATA);
        sel_txs = bus_addr == ADDR_W'(OFS_TX_STAT);
        sel_txd = bus_addr == ADDR_W'(OFS_TX_DATA);
        sel_id  = bus_addr == ADDR_W'(OFS_ID);
    end

    cons_rx_path #(.CHAR_W(CHAR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_wr   (bus_wr && sel_rxs),
        .wr_ie     (bus_wdata[IE_BIT]),
        .data_rd   (bus_rd && sel_rxd),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .ie        (rx_ie),
        .stat_byte (rx_stat),
        .data_byte (rx_data)
    );

    cons_tx_path #(.CHAR_W(CHAR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_wr   (bus_wr && sel_txs),
        .wr_ie     (bus_wdata[IE_BIT]),
        .data_wr   (bus_wr && sel_txd),
        .wr_byte   (bus_wdata[CHAR_W-1:0]),
        .ie        (tx_ie),
        .stat_byte (tx_stat),
        .tx_byte   (tx_byte),
        .tx_valid  (tx_valid)
    );

    cons_irq_ctl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_cause (rx_ie && rx_valid),
        .tx_cause (tx_ie),
        .stat_wr  (bus_wr && (sel_rxs || sel_txs)),
        .irq      (irq),
        .pend     (pend),
        .vec      (irq_vector)
    );

    // Read data multiplexer; unmapped and write-only offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_rxs)      bus_rdata = DATA_W'(rx_stat);
        else if (sel_rxd) bus_rdata = DATA_W'(rx_data);
        else if (sel_txs) bus_rdata = DATA_W'(tx_stat);
        else if (sel_id)  bus_rdata = DATA_W'(ID_VALUE);
    end

    // System status word carrying only the sticky pending flag.
    always_comb begin
        sys_status           = '0;
        sys_status[PEND_BIT] = pend;
    end

    AST_TXV_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_wr && sel_txd)); // R4
    AST_POP_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel_rxd && !rx_valid) |-> (bus_rdata == '0 && !rx_ready)); // R5
    AST_RX_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(rx_ie && rx_valid)) |-> irq_vector == VEC_RX); // R8
endmodule

// File: tb/cons_port_bench.sv
module cons_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        irq;
    logic [7:0]  irq_vector;
    logic [31:0] sys_status;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cons_port u_cons_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .irq(irq),
        .irq_vector(irq_vector), .sys_status(sys_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [31:0] d, output logic rdy);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata; rdy = rx_ready;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic r;
        repeat (3) @(negedge clk);
        chk("R12 irq", {31'b0, irq}, 0);
        chk("R12 vector", {24'b0, irq_vector}, 0);
        chk("R12 sys_status", sys_status, 0);
        chk("R12 tx_valid", {31'b0, tx_valid}, 0);
        bus_addr = 9'h088; #1;
        chk("R12 tx status in reset", bus_rdata, 0);
        bus_addr = 9'h080; #1;
        chk("R12 rx status in reset", bus_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(9'h088, d, r);
        chk("R3 tx ready after reset", d, 32'h80);
    endtask

    task automatic t_tx_emit();
        logic [31:0] d; logic r;
        bus_write(9'h08C, 32'h1234_56A7);
        chk("R4 tx_valid", {31'b0, tx_valid}, 1);
        chk("R4 tx_byte", {24'b0, tx_byte}, 32'hA7);
        @(negedge clk);
        chk("R4 tx_valid one cycle", {31'b0, tx_valid}, 0);
        bus_read(9'h088, d, r);
        chk("R3 ready unchanged", d, 32'h80);
    endtask

    task automatic t_rx_read();
        logic [31:0] d; logic r;
        rx_byte = 8'h5A; rx_valid = 1'b1;
        bus_read(9'h080, d, r);
        chk("R2 rx status avail", d, 32'h80);
        chk("R5 no pop on status read", {31'b0, r}, 0);
        bus_read(9'h084, d, r);
        chk("R5 rx data", d, 32'h5A);
        chk("R5 pop pulse", {31'b0, r}, 1);
        rx_valid = 1'b0;
        bus_read(9'h084, d, r);
        chk("R5 empty read zero", d, 0);
        chk("R5 no pop when empty", {31'b0, r}, 0);
        bus_read(9'h080, d, r);
        chk("R2 rx status empty", d, 0);
    endtask

    task automatic t_rx_irq();
        logic [31:0] d; logic r;
        rx_byte = 8'h33; rx_valid = 1'b1;
        bus_write(9'h080, 32'h40);
        chk("R6 irq not yet", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R6 irq", {31'b0, irq}, 1);
        chk("R6 vector", {24'b0, irq_vector}, 32'hF8);
        chk("R9 pending set", sys_status, 32'h1000_0000);
        bus_read(9'h080, d, r);
        chk("R2 rx status enabled", d, 32'hC0);
        bus_write(9'h080, 32'h40);
        chk("R9 irq drop on status write", {31'b0, irq}, 0);
        chk("R9 pending cleared", sys_status, 0);
        @(negedge clk);
        chk("R9 irq back", {31'b0, irq}, 1);
        chk("R9 pending back", sys_status, 32'h1000_0000);
        rx_valid = 1'b0;
        bus_write(9'h080, 32'h0);
        @(negedge clk);
        chk("R6 irq off", {31'b0, irq}, 0);
        chk("R9 pending off", sys_status, 0);
    endtask

    task automatic t_tx_irq();
        logic [31:0] d; logic r;
        bus_write(9'h088, 32'h40);
        @(negedge clk);
        chk("R7 irq", {31'b0, irq}, 1);
        chk("R7 vector", {24'b0, irq_vector}, 32'hFC);
        bus_read(9'h088, d, r);
        chk("R2 tx status enabled", d, 32'hC0);
        bus_write(9'h088, 32'h0);
        @(negedge clk);
        chk("R7 irq off", {31'b0, irq}, 0);
        chk("R9 pending off", sys_status, 0);
    endtask

    task automatic t_priority();
        rx_byte = 8'h11; rx_valid = 1'b1;
        bus_write(9'h088, 32'h40);
        bus_write(9'h080, 32'h40);
        @(negedge clk);
        chk("R8 both causes vector", {24'b0, irq_vector}, 32'hF8);
        chk("R8 irq", {31'b0, irq}, 1);
        rx_valid = 1'b0;
        @(negedge clk);
        chk("R8 tx vector after rx gone", {24'b0, irq_vector}, 32'hFC);
        chk("R8 irq held", {31'b0, irq}, 1);
        bus_write(9'h080, 32'h0);
        bus_write(9'h088, 32'h0);
        @(negedge clk);
        chk("R8 idle", {31'b0, irq}, 0);
    endtask

    task automatic t_sticky();
        logic [31:0] d; logic r;
        rx_byte = 8'h7E; rx_valid = 1'b1;
        bus_write(9'h080, 32'h40);
        @(negedge clk);
        chk("R9 irq up", {31'b0, irq}, 1);
        bus_read(9'h084, d, r);
        chk("R5 popped byte", d, 32'h7E);
        rx_valid = 1'b0;
        @(negedge clk);
        chk("R9 irq falls with cause", {31'b0, irq}, 0);
        chk("R9 pending sticky", sys_status, 32'h1000_0000);
        @(negedge clk);
        chk("R9 pending still sticky", sys_status, 32'h1000_0000);
        bus_write(9'h088, 32'h0);
        chk("R9 cleared by tx status write", sys_status, 0);
        bus_write(9'h080, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] d; logic r;
        bus_write(9'h100, 32'h40);
        chk("R10 no tx strobe 0x100", {31'b0, tx_valid}, 0);
        bus_write(9'h108, 32'hFF);
        chk("R10 no tx strobe 0x108", {31'b0, tx_valid}, 0);
        @(negedge clk);
        chk("R10 no irq", {31'b0, irq}, 0);
        bus_read(9'h080, d, r);
        chk("R10 rx status untouched", d, 0);
        bus_read(9'h088, d, r);
        chk("R10 tx status untouched", d, 32'h80);
        bus_read(9'h100, d, r);
        chk("R10 id value", d, 128);
        bus_read(9'h108, d, r);
        chk("R10 scratch reads zero", d, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic r;
        bus_write(9'h180, 32'h40);
        bus_write(9'h188, 32'h40);
        bus_write(9'h18C, 32'h55);
        chk("R11 no tx strobe", {31'b0, tx_valid}, 0);
        @(negedge clk);
        chk("R11 no irq", {31'b0, irq}, 0);
        bus_read(9'h080, d, r);
        chk("R11 rx enable untouched", d, 0);
        bus_read(9'h088, d, r);
        chk("R11 tx enable untouched", d, 32'h80);
        rx_byte = 8'h99; rx_valid = 1'b1;
        bus_read(9'h184, d, r);
        chk("R11 alias read zero", d, 0);
        chk("R11 alias no pop", {31'b0, r}, 0);
        bus_read(9'h004, d, r);
        chk("R11 unmapped read zero", d, 0);
        bus_read(9'h084, d, r);
        chk("R1 data offset", d, 32'h99);
        rx_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_tx_emit();
        t_rx_read();
        t_rx_irq();
        t_tx_irq();
        t_priority();
        t_sticky();
        t_ignored();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule